// File: doc/BRIEF.md
# Narrow Load Address and Extend Unit

This block carries out byte and halfword loads for a 32-bit datapath. In the cycle an operation is issued, it forms the effective address from the operand values. Six addressing modes are available. The block then raises a single memory read request carrying that address and the access size. The memory returns read data one cycle later. On that return cycle the block extends the selected byte or halfword to 32 bits and presents it for the destination register.

Two of the modes change the pointer they read through. For these modes the block also presents the modified pointer for write-back, in the same cycle as the destination write. A conditional mode runs only when the caller's condition flag is true. When the flag is false, that mode has no effect at all. The block does not decode condition codes or check alignment.

Top module: `nload_unit`

## Requirements
- R1: Mode code 0 (post-increment) requests address `ptr` and later writes back `ptr + 1` for a byte or `ptr + 2` for a halfword.
- R2: Mode code 1 (pre-decrement) requests `ptr - 1` for a byte or `ptr - 2` for a halfword, and writes back that same address as the new pointer.
- R3: Mode code 2 (short offset) requests `ptr + ZE(disp[2:0])`, with the offset shifted left by one for a halfword.
- R4: Mode code 3 (long offset) requests `ptr + SE(disp[15:0])`, with no scaling for either size.
- R5: Mode code 4 (indexed) requests `base + (index << shamt)`, where `shamt` is 2 bits.
- R6: Mode code 5 (conditional) with `cond_ok` high requests `ptr + ZE(disp[8:0])`, with the offset shifted left by one for a halfword.
- R7: Mode code 5 with `cond_ok` low raises no request, and neither `rd_we` nor `ptr_we` rises in the following cycle. Mode codes 6 and 7 behave the same way.
- R8: An unsigned load (`is_signed`=0) produces its byte or halfword zero-extended to 32 bits.
- R9: A signed load (`is_signed`=1) produces its byte or halfword sign-extended from the top bit of that field.
- R10: `mem_req` is combinational with `issue_valid`. `rd_we` is high exactly in the cycle after a request. `ptr_we` is high in that same cycle, and only for mode codes 0 and 1.
- R11: A halfword is taken from `mem_rdata[15:0]` and a byte from `mem_rdata[7:0]`. `mem_half` is 1 for a halfword access and 0 for a byte access.
- R12: While and right after `rst` is high, `rd_we` and `ptr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation present this cycle |
| mode | input | 3 | Addressing mode code (0..5, 6 and 7 reserved) |
| is_half | input | 1 | 1 = halfword, 0 = byte |
| is_signed | input | 1 | 1 = sign-extend result |
| ptr | input | 32 | Pointer register value |
| base | input | 32 | Base register for indexed mode |
| index | input | 32 | Index register for indexed mode |
| shamt | input | 2 | Index shift amount |
| disp | input | 16 | Displacement field |
| cond_ok | input | 1 | Condition true for the conditional mode |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Read address |
| mem_half | output | 1 | Read size, 1 = halfword |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| rd_we | output | 1 | Destination write enable |
| rd_wdata | output | 32 | Extended load result |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_wdata | output | 32 | Updated pointer value |

## Verification
The request, its address and its size are combinational with the issue. The bench drives them just after a falling edge and reads them back 1 ns later, inside the same cycle. The destination result and the pointer update are due one rising edge later. The bench places the read data on `mem_rdata` after that edge's falling edge, then samples `rd_we`, `rd_wdata`, `ptr_we` and `ptr_wdata` 1 ns later. The sweep covers every mode code, both sizes and both signedness settings, over three operand sets. Each set carries its own condition value and its own read data, with the high bits set.

// File: rtl/nload_pkg.sv
package nload_pkg;

    localparam int XLEN = 32;
    localparam int DISPW = 16;

    typedef enum logic [2:0] {
        AM_POSTINC = 3'd0,
        AM_PREDEC  = 3'd1,
        AM_SHORT   = 3'd2,
        AM_LONG    = 3'd3,
        AM_INDEX   = 3'd4,
        AM_COND    = 3'd5,
        AM_RSV6    = 3'd6,
        AM_RSV7    = 3'd7
    } addr_mode_e;

    typedef struct packed {
        logic            valid;
        logic            half;
        logic            signd;
        logic            wb;
        logic [XLEN-1:0] new_ptr;
    } pend_t;

    function automatic logic [XLEN-1:0] size_step(input logic half);
        return half ? XLEN'(2) : XLEN'(1);
    endfunction

endpackage

// File: rtl/nload_agen.sv
module nload_agen
    import nload_pkg::*;
(
    input  logic             issue_valid,
    input  addr_mode_e       mode,
    input  logic             is_half,
    input  logic [XLEN-1:0]  ptr,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  index,
    input  logic [1:0]       shamt,
    input  logic [DISPW-1:0] disp,
    input  logic             cond_ok,
    output logic             req,
    output logic             autoinc,
    output logic [XLEN-1:0]  addr,
    output logic [XLEN-1:0]  new_ptr
);
    logic [XLEN-1:0] step;
    logic [XLEN-1:0] off_short;
    logic [XLEN-1:0] off_long;
    logic [XLEN-1:0] off_cond;

    always_comb begin
        step      = size_step(is_half);
        off_short = XLEN'(disp[2:0]) << is_half;
        off_long  = {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
        off_cond  = XLEN'(disp[8:0]) << is_half;
        req       = 1'b0;
        autoinc   = 1'b0;
        addr      = ptr;
        new_ptr   = ptr;
        unique case (mode)
            AM_POSTINC: begin
                req     = issue_valid;
                autoinc = 1'b1;
                addr    = ptr;
                new_ptr = ptr + step;
            end
            AM_PREDEC: begin
                req     = issue_valid;
                autoinc = 1'b1;
                addr    = ptr - step;
                new_ptr = ptr - step;
            end
            AM_SHORT: begin
                req  = issue_valid;
                addr = ptr + off_short;
            end
            AM_LONG: begin
                req  = issue_valid;
                addr = ptr + off_long;
            end
            AM_INDEX: begin
                req  = issue_valid;
                addr = base + (index << shamt);
            end
            AM_COND: begin
                req  = issue_valid & cond_ok;
                addr = ptr + off_cond;
            end
            default: begin
                req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nload_extend.sv
module nload_extend
    import nload_pkg::*;
(
    input  logic            half,
    input  logic            signd,
    input  logic [15:0]     raw,
    output logic [XLEN-1:0] value
);
    logic fill;

    always_comb begin
        fill = signd & (half ? raw[15] : raw[7]);
        if (half)
            value = {{(XLEN-16){fill}}, raw};
        else
            value = {{(XLEN-8){fill}}, raw[7:0]};
    end
endmodule

// File: rtl/nload_unit.sv
module nload_unit
    import nload_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [2:0]       mode,
    input  logic             is_half,
    input  logic             is_signed,
    input  logic [XLEN-1:0]  ptr,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  index,
    input  logic [1:0]       shamt,
    input  logic [DISPW-1:0] disp,
    input  logic             cond_ok,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    output logic             mem_half,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             rd_we,
    output logic [XLEN-1:0]  rd_wdata,
    output logic             ptr_we,
    output logic [XLEN-1:0]  ptr_wdata
);
    logic            req;
    logic            autoinc;
    logic [XLEN-1:0] new_ptr;
    logic            unused_rdata_hi;
    pend_t           pend_q;

    assign unused_rdata_hi = ^mem_rdata[XLEN-1:16];

    nload_agen u_agen (
        .issue_valid (issue_valid),
        .mode        (addr_mode_e'(mode)),
        .is_half     (is_half),
        .ptr         (ptr),
        .base        (base),
        .index       (index),
        .shamt       (shamt),
        .disp        (disp),
        .cond_ok     (cond_ok),
        .req         (req),
        .autoinc     (autoinc),
        .addr        (mem_addr),
        .new_ptr     (new_ptr)
    );

    assign mem_req  = req;
    assign mem_half = is_half;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q.valid   <= req;
            pend_q.half    <= is_half;
            pend_q.signd   <= is_signed;
            pend_q.wb      <= req & autoinc;
            pend_q.new_ptr <= new_ptr;
        end
    end

    nload_extend u_ext (
        .half  (pend_q.half),
        .signd (pend_q.signd),
        .raw   (mem_rdata[15:0]),
        .value (rd_wdata)
    );

    assign rd_we     = pend_q.valid;
    assign ptr_we    = pend_q.wb;
    assign ptr_wdata = pend_q.new_ptr;
endmodule

// File: rtl/nload_unit_chk.sv
module nload_unit_chk
    import nload_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            issue_valid,
    input logic [2:0]      mode,
    input logic            is_signed,
    input logic            cond_ok,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_half,
    input logic            rd_we,
    input logic [XLEN-1:0] rd_wdata,
    input logic            ptr_we,
    input logic [XLEN-1:0] ptr_wdata
);
    assert_postinc_wb_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mode == 3'd0) |=>
            (ptr_we && ptr_wdata == $past(mem_addr) + ($past(mem_half) ? 32'd2 : 32'd1)));

    assert_predec_wb_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mode == 3'd1) |=> (ptr_we && ptr_wdata == $past(mem_addr)));

    assert_cond_false_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && mode == 3'd5 && !cond_ok) |-> !mem_req);

    assert_cond_false_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        !mem_req |=> (!rd_we && !ptr_we));

    assert_unsigned_byte_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !is_signed && !mem_half) |=> (rd_wdata[31:8] == 24'd0));

    assert_signed_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && is_signed && !mem_half) |=> (rd_wdata[31:8] == {24{rd_wdata[7]}}));

    assert_write_timing_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> rd_we);

    assert_ptr_only_with_rd_R10: assert property (@(posedge clk) disable iff (rst)
        ptr_we |-> rd_we);

    assert_req_needs_issue_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> issue_valid);

    assert_reset_quiet_R12: assert property (@(posedge clk)
        $past(rst) |-> (!rd_we && !ptr_we));
endmodule

bind nload_unit nload_unit_chk u_chk (.*);

// File: tb/nload_unit_bench.sv
module nload_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [2:0]  mode;
    logic        is_half;
    logic        is_signed;
    logic [31:0] ptr;
    logic [31:0] base;
    logic [31:0] index;
    logic [1:0]  shamt;
    logic [15:0] disp;
    logic        cond_ok;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_half;
    logic [31:0] mem_rdata;
    logic        rd_we;
    logic [31:0] rd_wdata;
    logic        ptr_we;
    logic [31:0] ptr_wdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nload_unit u_nload_unit (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_one(input int m, input logic h, input logic s, input int set);
        logic [31:0] p, b, ix, rdat, step, addr, np, exp_val;
        logic [15:0] d;
        logic [1:0]  sh;
        logic        c, req, wb;
        logic [15:0] fld;
        case (set)
            0: begin p = 32'h0000_1000; b = 32'h2000_0000; ix = 32'h0000_0013;
                     sh = 2'd3; d = 16'h81F5; c = 1'b1; rdat = 32'hDEAD_80F7; end
            1: begin p = 32'h0000_0001; b = 32'hFFFF_FFF0; ix = 32'h0000_0005;
                     sh = 2'd2; d = 16'h7FFF; c = 1'b0; rdat = 32'h1234_7F85; end
            default: begin p = 32'h8000_0000; b = 32'h0000_0100; ix = 32'hFFFF_FFFF;
                     sh = 2'd1; d = 16'h01FB; c = 1'b1; rdat = 32'hFFFF_0042; end
        endcase
        step = h ? 32'd2 : 32'd1;
        addr = p; np = p; wb = 1'b0; req = 1'b1;
        case (m)
            0: begin addr = p; np = p + step; wb = 1'b1; end
            1: begin addr = p - step; np = p - step; wb = 1'b1; end
            2: addr = p + ({29'd0, d[2:0]} << h);
            3: addr = p + {{16{d[15]}}, d};
            4: addr = b + (ix << sh);
            5: begin addr = p + ({23'd0, d[8:0]} << h); req = c; end
            default: req = 1'b0;
        endcase
        fld = h ? rdat[15:0] : {8'd0, rdat[7:0]};
        if (h) exp_val = {{16{s & fld[15]}}, fld};
        else   exp_val = {{24{s & fld[7]}}, fld[7:0]};

        @(negedge clk);
        issue_valid = 1'b1; mode = m[2:0]; is_half = h; is_signed = s;
        ptr = p; base = b; index = ix; shamt = sh; disp = d; cond_ok = c;
        mem_rdata = 32'h5A5A_5A5A;
        #1;
        chk({tag_of(m), " mem_req"}, {31'd0, mem_req}, {31'd0, req});
        if (req) begin
            chk({tag_of(m), " mem_addr"}, mem_addr, addr);
            chk("R11 mem_half", {31'd0, mem_half}, {31'd0, h});
        end
        @(negedge clk);
        issue_valid = 1'b0;
        mem_rdata = rdat;
        #1;
        chk("R10 rd_we", {31'd0, rd_we}, {31'd0, req});
        chk("R10 ptr_we", {31'd0, ptr_we}, {31'd0, req & wb});
        if (req) begin
            chk(s ? "R9 rd_wdata" : "R8 rd_wdata", rd_wdata, exp_val);
            if (wb) chk({tag_of(m), " ptr_wdata"}, ptr_wdata, np);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; issue_valid = 1'b0; mode = 3'd0; is_half = 1'b0; is_signed = 1'b0;
        ptr = '0; base = '0; index = '0; shamt = '0; disp = '0; cond_ok = 1'b0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        // R12: quiet in reset even with an operation offered
        issue_valid = 1'b1;
        @(negedge clk);
        #1;
        chk("R12 rd_we", {31'd0, rd_we}, 32'd0);
        chk("R12 ptr_we", {31'd0, ptr_we}, 32'd0);
        issue_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R12 rd_we after", {31'd0, rd_we}, 32'd0);
        // sweep: modes R1..R7, sizes R11, signedness R8/R9, timing R10
        for (int m = 0; m < 8; m++)
            for (int h = 0; h < 2; h++)
                for (int s = 0; s < 2; s++)
                    for (int set = 0; set < 3; set++)
                        run_one(m, h[0], s[0], set);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule